// File: doc/BRIEF.md
# APB Wait-State Protocol Monitor

This block is a passive observer for one select line of an APB bus. It never drives the bus. On each clock edge it samples select, enable, ready, address, direction, write data and the slave error bit. A small phase machine follows each transfer from its setup cycle through any number of wait cycles to the single cycle that completes it. Whenever the manager breaks the wait-state discipline, the block sets one bit in a sticky violation vector. Each kind of fault has its own bit. The rules it enforces are these: the access-defining signals stay frozen until completion, enable does not drop while the access is still waiting, enable never appears without a setup cycle, and each transfer commits once.

The block also keeps running totals of completed transfers, erroring completions and wait cycles, and it reports how many wait cycles the most recent transfer took. An optional limit flags any access that waits longer than a configured number of cycles. All outputs are registered and reflect the bus cycle sampled at the previous edge. Software, or a test environment, clears the violation bits with a one-cycle pulse on the clear input.

The phase machine has three states. PH_IDLE means the previous cycle was idle or was a completion. PH_SETUP means the previous cycle was a setup cycle. PH_ACCESS means the previous cycle was a wait cycle. The transitions are as follows:
- PH_IDLE to PH_SETUP on select high with enable low.
- PH_SETUP or PH_ACCESS to PH_ACCESS on select, enable high and ready low. This is a wait cycle.
- PH_SETUP or PH_ACCESS to PH_IDLE on select, enable and ready all high. This is a completion.
- PH_SETUP or PH_ACCESS to PH_IDLE when select goes low. This is an abandoned access.
- PH_SETUP or PH_ACCESS to PH_SETUP on select high with enable low. This is a fresh setup.

Top module: `apbmon_top`

## Requirements
- R1: After reset, every violation bit, all three counters and the last-wait output are zero.
- R2: The transfer counter rises by exactly one per transfer. This happens on the first cycle after a setup in which select, enable and ready are all high. It does not change during wait cycles.
- R3: Each cycle with select and enable high and ready low inside a transfer adds one to the wait total. At completion the last-wait output takes the number of such cycles in that transfer.
- R4: A setup cycle directly after a completion cycle, with no idle cycle between them, is legal. It sets no violation bit and its transfer is counted.
- R5: Bit 0 (hold) is set when, in a cycle following a setup or wait cycle, select is low, or enable is high while address, direction or write data differ from the values seen in the setup cycle.
- R6: Bit 1 (enable drop) is set when enable is low with select high in the cycle after a wait cycle. That cycle is then treated as a new setup.
- R7: Bit 2 (missing setup) is set when select and enable are both high in a cycle that follows an idle or completion cycle. No transfer is counted for it.
- R8: Bit 3 (enable without select) is set in any cycle with enable high and select low.
- R9: With TIMEOUT_EN set, bit 4 (timeout) is set on the wait cycle that takes one transfer past MAX_WAIT wait cycles. Exactly MAX_WAIT waits sets nothing.
- R10: The error counter rises by one when the slave error input is high in a completion cycle. Its value in any other cycle has no effect.
- R11: Violation bits stay set until clr_i is high at an edge, which clears them. A violation sampled at that same edge is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Observed select line |
| en_i | input | 1 | Observed enable |
| rdy_i | input | 1 | Observed ready from the subordinate |
| addr_i | input | AW | Observed address |
| wr_i | input | 1 | Observed direction, high for write |
| wdata_i | input | DW | Observed write data |
| err_i | input | 1 | Observed slave error |
| clr_i | input | 1 | Clears the violation bits |
| viol_o | output | 5 | Sticky violations: bit 0 hold, bit 1 enable drop, bit 2 missing setup, bit 3 enable without select, bit 4 timeout |
| xfer_cnt_o | output | CNT_W | Completed transfers |
| err_cnt_o | output | CNT_W | Completions with slave error high |
| wait_tot_o | output | CNT_W | Wait cycles over all transfers |
| last_wait_o | output | WAIT_W | Wait cycles of the most recent completed transfer |

## Verification
The bench builds the block with AW=16, DW=32, CNT_W=16, WAIT_W=8, TIMEOUT_EN=1 and MAX_WAIT=4. With this small limit the timeout boundary can be reached in a few cycles: a transfer with four waits and one with five sit on either side of it. The random transfers keep their waits between zero and three, so they never trip the limit. Those random transfers mix idle gaps with back-to-back chaining, and err_i is driven high on wait and idle cycles, so the bench also shows that the error bit is ignored outside completion.

// File: rtl/apbmon_pkg.sv
package apbmon_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } phase_t;

    localparam int unsigned V_HOLD    = 0;
    localparam int unsigned V_DROP    = 1;
    localparam int unsigned V_NOSETUP = 2;
    localparam int unsigned V_NOSEL   = 3;
    localparam int unsigned V_TIMEOUT = 4;
    localparam int unsigned V_NUM     = 5;
endpackage

// File: rtl/apbmon_phase.sv
module apbmon_phase
    import apbmon_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sel_i,
    input  logic             en_i,
    input  logic             rdy_i,
    input  logic             frame_diff_i,
    output logic             setup_cyc_o,
    output logic             wait_cyc_o,
    output logic             done_cyc_o,
    output logic [V_NUM-1:0] ev_o
);
    phase_t state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PH_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        setup_cyc_o = 1'b0;
        wait_cyc_o  = 1'b0;
        done_cyc_o  = 1'b0;
        ev_o        = '0;
        ev_o[V_NOSEL] = en_i && !sel_i;
        unique case (state_q)
            PH_IDLE: begin
                if (sel_i && !en_i) begin
                    setup_cyc_o = 1'b1;
                    state_d     = PH_SETUP;
                end else if (sel_i && en_i) begin
                    ev_o[V_NOSETUP] = 1'b1;
                end
            end
            PH_SETUP, PH_ACCESS: begin
                if (!sel_i) begin
                    ev_o[V_HOLD] = 1'b1;
                    state_d      = PH_IDLE;
                end else if (!en_i) begin
                    setup_cyc_o  = 1'b1;
                    ev_o[V_DROP] = (state_q == PH_ACCESS);
                    state_d      = PH_SETUP;
                end else begin
                    ev_o[V_HOLD] = frame_diff_i;
                    if (rdy_i) begin
                        done_cyc_o = 1'b1;
                        state_d    = PH_IDLE;
                    end else begin
                        wait_cyc_o = 1'b1;
                        state_d    = PH_ACCESS;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // R7
    access_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_ACCESS) |-> ($past(state_q) != PH_IDLE));

    // R2
    single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_cyc_o |=> !done_cyc_o);
endmodule

// File: rtl/apbmon_frame.sv
module apbmon_frame #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          setup_cyc_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          diff_o
);
    localparam int unsigned FW = AW + DW + 1;

    logic [FW-1:0] cap_q;
    logic [FW-1:0] now_w;

    assign now_w  = {addr_i, wr_i, wdata_i};
    assign diff_o = (now_w != cap_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cap_q <= '0;
        else if (setup_cyc_i) cap_q <= now_w;
    end
endmodule

// File: rtl/apbmon_tally.sv
module apbmon_tally #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned WAIT_W     = 8,
    parameter int unsigned MAX_WAIT   = 16,
    parameter bit          TIMEOUT_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              setup_cyc_i,
    input  logic              wait_cyc_i,
    input  logic              done_cyc_i,
    input  logic              err_i,
    output logic [CNT_W-1:0]  xfer_cnt_o,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic [CNT_W-1:0]  wait_tot_o,
    output logic [WAIT_W-1:0] last_wait_o,
    output logic              timeout_o
);
    localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(MAX_WAIT);
    localparam logic [WAIT_W-1:0] WAIT_TOP = '1;

    logic [WAIT_W-1:0] cur_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q       <= '0;
            xfer_cnt_o  <= '0;
            err_cnt_o   <= '0;
            wait_tot_o  <= '0;
            last_wait_o <= '0;
        end else begin
            if (setup_cyc_i)
                cur_q <= '0;
            else if (wait_cyc_i && cur_q != WAIT_TOP)
                cur_q <= cur_q + 1'b1;
            if (wait_cyc_i)
                wait_tot_o <= wait_tot_o + 1'b1;
            if (done_cyc_i) begin
                xfer_cnt_o  <= xfer_cnt_o + 1'b1;
                last_wait_o <= cur_q;
                if (err_i) err_cnt_o <= err_cnt_o + 1'b1;
            end
        end
    end

    generate
        if (TIMEOUT_EN) begin : g_limit
            assign timeout_o = wait_cyc_i && (cur_q == WAIT_LIM);
        end else begin : g_nolimit
            assign timeout_o = 1'b0;
        end
    endgenerate

    // R2
    xfer_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_cnt_o == $past(xfer_cnt_o)) || (xfer_cnt_o == $past(xfer_cnt_o) + CNT_W'(1)));

    // R10
    err_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_cnt_o != $past(err_cnt_o)) |-> (xfer_cnt_o != $past(xfer_cnt_o)));

    // R3
    last_wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_cnt_o == $past(xfer_cnt_o)) |-> $stable(last_wait_o));
endmodule

// File: rtl/apbmon_top.sv
module apbmon_top
    import apbmon_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned DW         = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned WAIT_W     = 8,
    parameter int unsigned MAX_WAIT   = 16,
    parameter bit          TIMEOUT_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              en_i,
    input  logic              rdy_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              err_i,
    input  logic              clr_i,
    output logic [V_NUM-1:0]  viol_o,
    output logic [CNT_W-1:0]  xfer_cnt_o,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic [CNT_W-1:0]  wait_tot_o,
    output logic [WAIT_W-1:0] last_wait_o
);
    logic             setup_cyc, wait_cyc, done_cyc, frame_diff, timeout;
    logic [V_NUM-1:0] phase_ev, ev_all;

    apbmon_phase u_phase (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sel_i        (sel_i),
        .en_i         (en_i),
        .rdy_i        (rdy_i),
        .frame_diff_i (frame_diff),
        .setup_cyc_o  (setup_cyc),
        .wait_cyc_o   (wait_cyc),
        .done_cyc_o   (done_cyc),
        .ev_o         (phase_ev)
    );

    apbmon_frame #(.AW(AW), .DW(DW)) u_frame (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .setup_cyc_i (setup_cyc),
        .addr_i      (addr_i),
        .wr_i        (wr_i),
        .wdata_i     (wdata_i),
        .diff_o      (frame_diff)
    );

    apbmon_tally #(
        .CNT_W(CNT_W), .WAIT_W(WAIT_W), .MAX_WAIT(MAX_WAIT), .TIMEOUT_EN(TIMEOUT_EN)
    ) u_tally (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .setup_cyc_i (setup_cyc),
        .wait_cyc_i  (wait_cyc),
        .done_cyc_i  (done_cyc),
        .err_i       (err_i),
        .xfer_cnt_o  (xfer_cnt_o),
        .err_cnt_o   (err_cnt_o),
        .wait_tot_o  (wait_tot_o),
        .last_wait_o (last_wait_o),
        .timeout_o   (timeout)
    );

    always_comb begin
        ev_all            = phase_ev;
        ev_all[V_TIMEOUT] = timeout;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) viol_o <= '0;
        else         viol_o <= (clr_i ? '0 : viol_o) | ev_all;
    end

    // R11
    sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(clr_i) |-> ((viol_o & $past(viol_o)) == $past(viol_o)));

    // R8
    nosel_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !sel_i) |=> viol_o[V_NOSEL]);
endmodule

// File: tb/tb_apbmon_top.sv
`timescale 1ns/1ps
module tb_apbmon_top;
    localparam int unsigned MAXW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, en = 1'b0, rdy = 1'b0, wr = 1'b0, err = 1'b0, clr = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  viol;
    logic [15:0] xfer_cnt, err_cnt, wait_tot;
    logic [7:0]  last_wait;

    int n_chk = 0, n_fail = 0;
    int exp_x = 0, exp_e = 0, exp_w = 0, exp_last = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    apbmon_top #(
        .AW(16), .DW(32), .CNT_W(16), .WAIT_W(8), .MAX_WAIT(MAXW), .TIMEOUT_EN(1'b1)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .en_i(en), .rdy_i(rdy),
        .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .err_i(err), .clr_i(clr),
        .viol_o(viol), .xfer_cnt_o(xfer_cnt), .err_cnt_o(err_cnt),
        .wait_tot_o(wait_tot), .last_wait_o(last_wait)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic e, input logic r,
                        input logic [15:0] a, input logic w, input logic [31:0] d,
                        input logic er, input logic c);
        @(negedge clk);
        sel = s; en = e; rdy = r; addr = a; wr = w; wdata = d; err = er; clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic c);
        step(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 32'h0, 1'b1, c);
    endtask

    // one legal transfer; err driven high on waits and idles to show it is ignored there
    task automatic xfer(input logic [15:0] a, input logic w, input logic [31:0] d,
                        input int nw, input logic e, input int gap);
        step(1'b1, 1'b0, 1'b0, a, w, d, 1'b1, 1'b0);
        for (int i = 0; i < nw; i++) step(1'b1, 1'b1, 1'b0, a, w, d, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1, a, w, d, e, 1'b0);
        exp_x++; exp_w += nw; exp_last = nw;
        if (e) exp_e++;
        for (int i = 0; i < gap; i++) idle(1'b0);
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " xfer"}, int'(xfer_cnt), exp_x);
        chk({tag, " err"}, int'(err_cnt), exp_e);
        chk({tag, " waits"}, int'(wait_tot), exp_w);
        chk({tag, " last"}, int'(last_wait), exp_last);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 viol", int'(viol), 0);
        chk_counts("R1");
        @(negedge clk); rst_n = 1'b1;
        idle(1'b0);

        // R2 R3 R10: two waits, error at completion; count frozen during waits
        step(1'b1, 1'b0, 1'b0, 16'h0040, 1'b1, 32'hA5A5_0001, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 16'h0040, 1'b1, 32'hA5A5_0001, 1'b1, 1'b0);
        chk("R2 no count in wait", int'(xfer_cnt), 0);
        step(1'b1, 1'b1, 1'b0, 16'h0040, 1'b1, 32'hA5A5_0001, 1'b1, 1'b0);
        chk("R3 waits running", int'(wait_tot), 2);
        step(1'b1, 1'b1, 1'b1, 16'h0040, 1'b1, 32'hA5A5_0001, 1'b1, 1'b0);
        exp_x = 1; exp_e = 1; exp_w = 2; exp_last = 2;
        chk_counts("R2 R3 R10 first");
        idle(1'b0);
        chk("R2 single commit", int'(xfer_cnt), 1);

        // R4 back-to-back chaining, R10 err ignored outside completion
        xfer(16'h0100, 1'b0, 32'h0, 0, 1'b0, 0);
        xfer(16'h0104, 1'b1, 32'h1234_5678, 1, 1'b0, 1);
        chk("R4 viol", int'(viol), 0);
        chk_counts("R4 R10");

        // R5 hold: address changes during a wait
        step(1'b1, 1'b0, 1'b0, 16'h0200, 1'b1, 32'h11, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 16'h0200, 1'b1, 32'h11, 1'b0, 1'b0);
        chk("R5 clean before change", int'(viol), 0);
        step(1'b1, 1'b1, 1'b1, 16'h0204, 1'b1, 32'h11, 1'b0, 1'b0);
        exp_x++; exp_w++; exp_last = 1;
        chk("R5 hold", int'(viol), 1);
        // R11 sticky then clear
        idle(1'b0);
        chk("R11 sticky", int'(viol), 1);
        idle(1'b1);
        chk("R11 cleared", int'(viol), 0);

        // R5 hold: select drops mid-access
        step(1'b1, 1'b0, 1'b0, 16'h0208, 1'b0, 32'h0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 16'h0208, 1'b0, 32'h0, 1'b0, 1'b0);
        exp_w++;
        idle(1'b0);
        chk("R5 sel drop", int'(viol), 1);
        idle(1'b1);

        // R6 enable drop after a wait, then a fresh setup completes cleanly
        step(1'b1, 1'b0, 1'b0, 16'h0300, 1'b1, 32'h22, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 16'h0300, 1'b1, 32'h22, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 16'h0300, 1'b1, 32'h22, 1'b0, 1'b0);
        chk("R6 drop", int'(viol), 2);
        step(1'b1, 1'b1, 1'b1, 16'h0300, 1'b1, 32'h22, 1'b1, 1'b0);
        exp_x++; exp_e++; exp_w++; exp_last = 0;
        chk_counts("R6");
        idle(1'b1);

        // R7 enable with select from idle: flagged, not counted
        step(1'b1, 1'b1, 1'b1, 16'h0400, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R7 missing setup", int'(viol), 4);
        chk("R7 not counted", int'(xfer_cnt), exp_x);
        idle(1'b1);

        // R8 enable without select, raised in the same cycle as a clear (R11)
        step(1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 32'h0, 1'b0, 1'b1);
        chk("R8 R11 set with clear", int'(viol), 8);
        idle(1'b1);
        chk("R11 clear", int'(viol), 0);

        // R9 timeout boundary
        xfer(16'h0500, 1'b0, 32'h0, MAXW, 1'b0, 1);
        chk("R9 at limit", int'(viol), 0);
        xfer(16'h0504, 1'b0, 32'h0, MAXW + 1, 1'b0, 1);
        chk("R9 past limit", int'(viol), 16);
        chk_counts("R9");
        idle(1'b1);

        // random legal traffic: R2 R3 R4 R10
        for (int k = 0; k < 40; k++) begin
            xfer(16'($urandom), 1'($urandom), $urandom, int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 2)));
            chk("R3 random last", int'(last_wait), exp_last);
        end
        chk("R4 random viol", int'(viol), 0);
        chk_counts("R2 R10 random");

        finish_run();
    end
endmodule